// File: doc/BRIEF.md
# Inter-Register Transfer Execution Unit

This block executes a single instruction group that moves or adds words among a 24-bit accumulator, a 24-bit auxiliary register, seven 15-bit index registers and a 64-word register file. A 24-bit instruction word is presented together with a one-cycle start strobe. The unit decodes it, performs exactly one transfer or one ones-complement addition, writes the single destination register and pulses a completion flag a fixed two clock edges after the strobe was accepted.

Index values are sign-extended to 24 bits whenever they meet a 24-bit register, and 24-bit values are cut to their low 15 bits whenever they land in an index register. Malformed words raise an illegal flag together with completion and leave every register untouched. Every register can be observed through read ports. The register file can also be loaded through a write port while the unit is idle, which is how operands enter the block.

Top module: `xfer_unit`

## Requirements
- R1: After reset the accumulator, the auxiliary register and all index registers read zero, and busy, done and illegal are low.
- R2: The instruction is accepted as part of this group only if bits 23:18 equal octal 53. Bits 17:15 select the sub-operation, bits 14:12 the index designator and bits 5:0 the register-file word. Any other opcode is illegal.
- R3: A start seen while idle is accepted at that clock edge. Busy is high for the following cycle. Done is high for exactly the cycle after that. A start seen while busy is ignored. A start in the done cycle is accepted.
- R4: Sub-operation 0 writes the ones-complement sum of accumulator and auxiliary register (end-around carry) to the accumulator and leaves the auxiliary register unchanged.
- R5: Sub-operation 1 writes accumulator plus the sign-extended index register to the accumulator, in ones-complement arithmetic.
- R6: Sub-operation 2 writes the low 15 bits of the ones-complement sum of the sign-extended index register and the accumulator back to that index register.
- R7: Sub-operation 3 copies the sign-extended index register to the accumulator. Sub-operation 4 copies the low 15 bits of the accumulator to the index register.
- R8: Index designator 0 reads as zero, and writes to it are dropped.
- R9: Sub-operation 5 is a register-file move whose direction is chosen by bits 8:6. The codes are: 0 word to auxiliary, 1 auxiliary to word, 2 word to accumulator, 3 accumulator to word, 4 word to index (low 15 bits kept), 5 index to word (sign-extended).
- R10: The illegal flag is raised together with done, and no register or word changes, in each of these cases: sub-operations 0 to 4 with any of bits 11:0 set, sub-operation 6 or 7, register-file code 6 or 7, or a register-file move with any of bits 11:9 set.
- R11: Only the destination changes. The source and all other registers keep their values.
- R12: A register-file write through the load port takes effect when the unit is idle and is ignored while busy. The read port returns the addressed word one cycle after the address is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for the presented instruction |
| instr_i | input | 24 | Instruction word |
| busy_o | output | 1 | Instruction in execution |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Completion of a malformed instruction |
| dbg_acc_o | output | 24 | Accumulator value |
| dbg_aux_o | output | 24 | Auxiliary register value |
| dbg_idx_sel_i | input | 3 | Index register selector for reading |
| dbg_idx_o | output | 15 | Selected index register value |
| dbg_rf_we_i | input | 1 | Register-file load strobe |
| dbg_rf_addr_i | input | 6 | Register-file read and load address |
| dbg_rf_wdata_i | input | 24 | Register-file load data |
| dbg_rf_rdata_o | output | 24 | Register-file word, one cycle after the address |

## Verification
The done cycle of one instruction can also be the accepting edge of the next. In that case a register-file word written at one edge is read for the following instruction at the very next edge. The bench provokes this by raising start exactly in a done cycle: a store of the accumulator is followed at once by a load of the same word into the auxiliary register. The run is judged correct only if busy reappears immediately, a second done follows two edges later, and the auxiliary register holds the freshly stored value and not the stale one. A second collision is a load-port write that arrives during a busy cycle. The bench checks that the word it targets keeps its old value.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int INSTR_W = 24;
  localparam logic [5:0] GRP_OPC = 6'o53;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_AQA,
    OP_ABA,
    OP_BAB,
    OP_BTA,
    OP_ATB,
    OP_RTQ,
    OP_QTR,
    OP_RTA,
    OP_ATR,
    OP_RTB,
    OP_BTR
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] idx;
    logic       bad;
  } dec_t;

endpackage

// File: rtl/xfer_dec.sv
module xfer_dec
  import xfer_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);

  logic [2:0]  sub;
  logic [2:0]  code;
  logic [11:0] field;
  op_e         op_raw;
  logic        bad_raw;

  assign sub   = instr_i[17:15];
  assign code  = instr_i[8:6];
  assign field = instr_i[11:0];

  always_comb begin
    op_raw  = OP_NONE;
    bad_raw = 1'b0;
    case (sub)
      3'd0: op_raw = OP_AQA;
      3'd1: op_raw = OP_ABA;
      3'd2: op_raw = OP_BAB;
      3'd3: op_raw = OP_BTA;
      3'd4: op_raw = OP_ATB;
      3'd5: begin
        case (code)
          3'd0: op_raw = OP_RTQ;
          3'd1: op_raw = OP_QTR;
          3'd2: op_raw = OP_RTA;
          3'd3: op_raw = OP_ATR;
          3'd4: op_raw = OP_RTB;
          3'd5: op_raw = OP_BTR;
          default: bad_raw = 1'b1;
        endcase
        if (field[11:9] != 3'b000) bad_raw = 1'b1;
      end
      default: bad_raw = 1'b1;
    endcase
    if (sub <= 3'd4 && field != 12'h000) bad_raw = 1'b1;
    if (instr_i[23:18] != GRP_OPC) bad_raw = 1'b1;
  end

  always_comb begin
    dec_o.idx = instr_i[14:12];
    dec_o.bad = bad_raw;
    dec_o.op  = bad_raw ? OP_NONE : op_raw;
  end

endmodule

// File: rtl/xfer_ocadd.sv
module xfer_ocadd #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);

  logic [W:0] raw;

  assign raw   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};

endmodule

// File: rtl/xfer_idxfile.sv
module xfer_idxfile #(
  parameter int IW = 15,
  parameter int N  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] waddr_i,
  input  logic [IW-1:0]        wdata_i,
  input  logic [$clog2(N)-1:0] raddr_a_i,
  output logic [IW-1:0]        rdata_a_o,
  input  logic [$clog2(N)-1:0] raddr_b_i,
  output logic [IW-1:0]        rdata_b_o
);

  logic [IW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          regs[g] <= '0;
        end else if (we_i && waddr_i == g) begin
          regs[g] <= wdata_i;
        end
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];

endmodule

// File: rtl/xfer_rf.sv
module xfer_rf #(
  parameter int W  = 24,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_a_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_a_i) rdata_a_o <= mem[raddr_a_i];
  end

  always_ff @(posedge clk) begin
    rdata_b_o <= mem[raddr_b_i];
  end

endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import xfer_pkg::*;
#(
  parameter int W     = 24,
  parameter int IW    = 15,
  parameter int NIDX  = 8,
  parameter int RF_AW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [INSTR_W-1:0]      instr_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    illegal_o,
  output logic [W-1:0]            dbg_acc_o,
  output logic [W-1:0]            dbg_aux_o,
  input  logic [$clog2(NIDX)-1:0] dbg_idx_sel_i,
  output logic [IW-1:0]           dbg_idx_o,
  input  logic                    dbg_rf_we_i,
  input  logic [RF_AW-1:0]        dbg_rf_addr_i,
  input  logic [W-1:0]            dbg_rf_wdata_i,
  output logic [W-1:0]            dbg_rf_rdata_o
);

  localparam int IDX_AW = $clog2(NIDX);
  localparam int EXT_W  = W - IW;

  logic               busy_q, done_q, bad_q;
  logic [INSTR_W-1:0] instr_q;
  logic [W-1:0]       acc_q, aux_q;
  logic               accept;
  dec_t               dec;

  logic [W-1:0]       rf_rd, rf_wdata, rf_xwd;
  logic [RF_AW-1:0]   rf_waddr;
  logic               rf_we, rf_xwe;

  logic [IW-1:0]      idx_rd, idx_wd;
  logic               idx_we;
  logic [W-1:0]       idx_ext, add_b, sum, acc_wd;
  logic               acc_we, aux_we;

  assign accept = start_i & ~busy_q;

  xfer_dec u_dec (
    .instr_i (instr_q),
    .dec_o   (dec)
  );

  assign rf_we    = rf_xwe | (dbg_rf_we_i & ~busy_q);
  assign rf_waddr = busy_q ? instr_q[RF_AW-1:0] : dbg_rf_addr_i;
  assign rf_wdata = busy_q ? rf_xwd : dbg_rf_wdata_i;

  xfer_rf #(.W(W), .AW(RF_AW)) u_rf (
    .clk       (clk),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .re_a_i    (accept),
    .raddr_a_i (instr_i[RF_AW-1:0]),
    .rdata_a_o (rf_rd),
    .raddr_b_i (dbg_rf_addr_i),
    .rdata_b_o (dbg_rf_rdata_o)
  );

  xfer_idxfile #(.IW(IW), .N(NIDX)) u_idx (
    .clk       (clk),
    .rst       (rst),
    .we_i      (idx_we),
    .waddr_i   (dec.idx[IDX_AW-1:0]),
    .wdata_i   (idx_wd),
    .raddr_a_i (dec.idx[IDX_AW-1:0]),
    .rdata_a_o (idx_rd),
    .raddr_b_i (dbg_idx_sel_i),
    .rdata_b_o (dbg_idx_o)
  );

  assign idx_ext = {{EXT_W{idx_rd[IW-1]}}, idx_rd};
  assign add_b   = (dec.op == OP_AQA) ? aux_q : idx_ext;

  xfer_ocadd #(.W(W)) u_add (
    .a_i   (acc_q),
    .b_i   (add_b),
    .sum_o (sum)
  );

  always_comb begin
    acc_we = 1'b0;
    acc_wd = sum;
    aux_we = 1'b0;
    idx_we = 1'b0;
    idx_wd = sum[IW-1:0];
    rf_xwe = 1'b0;
    rf_xwd = acc_q;
    if (busy_q) begin
      case (dec.op)
        OP_AQA, OP_ABA: acc_we = 1'b1;
        OP_BAB:         idx_we = 1'b1;
        OP_BTA: begin
          acc_we = 1'b1;
          acc_wd = idx_ext;
        end
        OP_ATB: begin
          idx_we = 1'b1;
          idx_wd = acc_q[IW-1:0];
        end
        OP_RTQ:         aux_we = 1'b1;
        OP_QTR: begin
          rf_xwe = 1'b1;
          rf_xwd = aux_q;
        end
        OP_RTA: begin
          acc_we = 1'b1;
          acc_wd = rf_rd;
        end
        OP_ATR:         rf_xwe = 1'b1;
        OP_RTB: begin
          idx_we = 1'b1;
          idx_wd = rf_rd[IW-1:0];
        end
        OP_BTR: begin
          rf_xwe = 1'b1;
          rf_xwd = idx_ext;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      instr_q <= '0;
      acc_q   <= '0;
      aux_q   <= '0;
    end else begin
      done_q <= 1'b0;
      bad_q  <= 1'b0;
      if (accept) begin
        instr_q <= instr_i;
        busy_q  <= 1'b1;
      end
      if (busy_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        bad_q  <= dec.bad;
      end
      if (acc_we) acc_q <= acc_wd;
      if (aux_we) aux_q <= rf_rd;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign illegal_o = bad_q;
  assign dbg_acc_o = acc_q;
  assign dbg_aux_o = aux_q;

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3
  busy_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> done_o);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(busy_o));

  // R10
  illegal_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (done_o && $stable(dbg_acc_o) && $stable(dbg_aux_o)));

  // R4
  aux_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && dec.op == OP_AQA) |-> $stable(dbg_aux_o));

endmodule

// File: tb/xfer_unit_tb.sv
`timescale 1ns/1ps
module xfer_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [23:0] instr_i = '0;
  logic        busy_o, done_o, illegal_o;
  logic [23:0] dbg_acc_o, dbg_aux_o;
  logic [2:0]  dbg_idx_sel_i = '0;
  logic [14:0] dbg_idx_o;
  logic        dbg_rf_we_i = 1'b0;
  logic [5:0]  dbg_rf_addr_i = '0;
  logic [23:0] dbg_rf_wdata_i = '0;
  logic [23:0] dbg_rf_rdata_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [23:0] m_a, m_q;
  logic [14:0] m_idx [8];
  logic [23:0] m_rf  [64];

  always #2.5 clk = ~clk;

  xfer_unit u_dut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .instr_i        (instr_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .illegal_o      (illegal_o),
    .dbg_acc_o      (dbg_acc_o),
    .dbg_aux_o      (dbg_aux_o),
    .dbg_idx_sel_i  (dbg_idx_sel_i),
    .dbg_idx_o      (dbg_idx_o),
    .dbg_rf_we_i    (dbg_rf_we_i),
    .dbg_rf_addr_i  (dbg_rf_addr_i),
    .dbg_rf_wdata_i (dbg_rf_wdata_i),
    .dbg_rf_rdata_o (dbg_rf_rdata_o)
  );

  function automatic logic [23:0] oc(input logic [23:0] x, input logic [23:0] y);
    logic [24:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s[24]) s = s + 25'd1;
    return s[23:0];
  endfunction

  function automatic logic [23:0] sx(input logic [14:0] v);
    return v[14] ? {9'h1FF, v} : {9'h000, v};
  endfunction

  function automatic logic [23:0] mk(input logic [2:0] sub, input logic [2:0] b,
                                     input logic [11:0] fld);
    return {6'o53, sub, b, fld};
  endfunction

  function automatic logic [23:0] rfop(input logic [2:0] code, input logic [2:0] b,
                                       input logic [5:0] ad);
    return mk(3'd5, b, {3'b000, code, ad});
  endfunction

  function automatic logic [23:0] pat(input int i);
    logic [31:0] t;
    case (i)
      0: t = 32'h000000;
      1: t = 32'h000001;
      2: t = 32'hFFFFFE;
      3: t = 32'h003FFF;
      4: t = 32'h004000;
      5: t = 32'h7FFFFF;
      6: t = 32'h800000;
      7: t = 32'hFFFFFF;
      default: t = (i * 32'h000A5B37) ^ (i << 17);
    endcase
    return t[23:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_exec(input logic [23:0] ins);
    logic [2:0]  b;
    logic [5:0]  ad;
    logic [23:0] bx, t;
    b  = ins[14:12];
    ad = ins[5:0];
    bx = sx(m_idx[b]);
    case (ins[17:15])
      3'd0: m_a = oc(m_a, m_q);
      3'd1: m_a = oc(m_a, bx);
      3'd2: begin t = oc(m_a, bx); m_idx[b] = t[14:0]; end
      3'd3: m_a = bx;
      3'd4: m_idx[b] = m_a[14:0];
      default: begin
        case (ins[8:6])
          3'd0: m_q = m_rf[ad];
          3'd1: m_rf[ad] = m_q;
          3'd2: m_a = m_rf[ad];
          3'd3: m_rf[ad] = m_a;
          3'd4: begin t = m_rf[ad]; m_idx[b] = t[14:0]; end
          default: m_rf[ad] = bx;
        endcase
      end
    endcase
    m_idx[0] = '0;
  endtask

  task automatic cmp_state(input string tag);
    chk({tag, " acc"}, dbg_acc_o, m_a);
    chk({tag, " aux"}, dbg_aux_o, m_q);
    for (int s = 0; s < 8; s++) begin
      dbg_idx_sel_i = s[2:0];
      #0.2;
      chk($sformatf("%s idx%0d", tag, s), dbg_idx_o, m_idx[s]);
    end
  endtask

  task automatic cmp_rf(input string tag, input logic [5:0] ad);
    @(negedge clk);
    dbg_rf_addr_i = ad;
    @(negedge clk);
    chk($sformatf("%s rf%0d", tag, ad), dbg_rf_rdata_o, m_rf[ad]);
  endtask

  task automatic issue(input logic [23:0] ins, input logic exp_bad, input string tag);
    @(negedge clk);
    start_i = 1'b1;
    instr_i = ins;
    @(negedge clk);
    start_i = 1'b0;
    chk({tag, " R3 busy"}, busy_o, 1);
    chk({tag, " R3 early done"}, done_o, 0);
    @(negedge clk);
    chk({tag, " R3 done"}, done_o, 1);
    chk({tag, " R3 idle"}, busy_o, 0);
    chk({tag, " illegal"}, illegal_o, exp_bad);
    @(negedge clk);
    chk({tag, " R3 done drop"}, done_o, 0);
    if (!exp_bad) model_exec(ins);
    cmp_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] b;
    logic [23:0] keep;
    m_a = '0;
    m_q = '0;
    for (int i = 0; i < 8; i++) m_idx[i] = '0;

    repeat (3) @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 illegal", illegal_o, 0);
    cmp_state("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R12: load every word while idle, read each back
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      dbg_rf_we_i    = 1'b1;
      dbg_rf_addr_i  = i[5:0];
      dbg_rf_wdata_i = pat(i);
      m_rf[i]        = pat(i);
    end
    @(negedge clk);
    dbg_rf_we_i = 1'b0;
    for (int i = 0; i < 64; i++) cmp_rf("R12 load", i[5:0]);

    // main sweep over words and designators (R2, R4-R9, R11)
    for (int k = 0; k < 64; k++) begin
      b = k[2:0];
      issue(rfop(3'd2, 3'd0, k[5:0]), 1'b0, "R9 R2 word->acc");
      issue(rfop(3'd0, 3'd0, 6'(63 - k)), 1'b0, "R9 word->aux");
      issue(mk(3'd0, 3'd0, 12'h000), 1'b0, "R4 R11 acc+aux");
      issue(rfop(3'd4, b, 6'((k * 5) % 64)), 1'b0, "R9 R8 word->idx");
      issue(mk(3'd1, b, 12'h000), 1'b0, "R5 acc+idx");
      issue(mk(3'd2, b, 12'h000), 1'b0, "R6 R8 idx+acc->idx");
      issue(mk(3'd3, b, 12'h000), 1'b0, "R7 R8 idx->acc");
      issue(mk(3'd4, b ^ 3'd3, 12'h000), 1'b0, "R7 R11 acc->idx");
      issue(rfop(3'd5, b ^ 3'd3, 6'((k + 17) % 64)), 1'b0, "R9 idx->word");
      cmp_rf("R9 idx->word", 6'((k + 17) % 64));
      issue(rfop(3'd3, 3'd0, k[5:0]), 1'b0, "R9 acc->word");
      cmp_rf("R9 acc->word", k[5:0]);
      issue(rfop(3'd1, 3'd0, 6'((k + 32) % 64)), 1'b0, "R9 aux->word");
      cmp_rf("R11 aux->word", 6'((k + 32) % 64));
    end

    // R10: malformed words change nothing
    for (int s = 0; s < 5; s++)
      for (int bit_i = 0; bit_i < 12; bit_i++)
        issue(mk(s[2:0], 3'd2, 12'(1 << bit_i)), 1'b1, "R10 low bits");
    issue(mk(3'd6, 3'd1, 12'h000), 1'b1, "R10 sub6");
    issue(mk(3'd7, 3'd1, 12'h000), 1'b1, "R10 sub7");
    issue(rfop(3'd6, 3'd1, 6'd4), 1'b1, "R10 code6");
    issue(rfop(3'd7, 3'd1, 6'd4), 1'b1, "R10 code7");
    for (int bit_i = 9; bit_i < 12; bit_i++) begin
      issue(mk(3'd5, 3'd0, 12'((1 << bit_i) | (3 << 6) | 5)), 1'b1, "R10 rf high bits");
      cmp_rf("R10 rf untouched", 6'd5);
    end
    issue({6'o52, 3'd2, 3'd0, 12'h000}, 1'b1, "R2 opcode 52");
    issue({6'o13, 3'd2, 3'd0, 12'h000}, 1'b1, "R2 opcode 13");
    issue({6'o00, 3'd0, 3'd0, 12'h000}, 1'b1, "R2 opcode 0");

    // R3: start while busy is ignored
    issue(rfop(3'd4, 3'd2, 6'd6), 1'b0, "R3 setup");
    @(negedge clk);
    start_i = 1'b1;
    instr_i = mk(3'd3, 3'd2, 12'h000);
    @(negedge clk);
    instr_i = rfop(3'd2, 3'd0, 6'd9);
    chk("R3 busy first", busy_o, 1);
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 one done", done_o, 1);
    @(negedge clk);
    chk("R3 second start ignored busy", busy_o, 0);
    chk("R3 second start ignored done", done_o, 0);
    model_exec(mk(3'd3, 3'd2, 12'h000));
    cmp_state("R3 ignored start");

    // R3: start in the done cycle, dependent through the register file
    issue(rfop(3'd2, 3'd0, 6'd10), 1'b0, "R3 setup acc");
    @(negedge clk);
    start_i = 1'b1;
    instr_i = rfop(3'd3, 3'd0, 6'd12);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk("R3 b2b first done", done_o, 1);
    start_i = 1'b1;
    instr_i = rfop(3'd0, 3'd0, 6'd12);
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 b2b accepted", busy_o, 1);
    chk("R3 b2b gap", done_o, 0);
    @(negedge clk);
    chk("R3 b2b second done", done_o, 1);
    model_exec(rfop(3'd3, 3'd0, 6'd12));
    model_exec(rfop(3'd0, 3'd0, 6'd12));
    @(negedge clk);
    cmp_state("R3 b2b");
    cmp_rf("R3 b2b", 6'd12);

    // R12: load-port write during busy is dropped
    keep = m_rf[20];
    @(negedge clk);
    start_i = 1'b1;
    instr_i = rfop(3'd2, 3'd0, 6'd3);
    @(negedge clk);
    start_i        = 1'b0;
    dbg_rf_we_i    = 1'b1;
    dbg_rf_addr_i  = 6'd20;
    dbg_rf_wdata_i = ~keep;
    @(negedge clk);
    dbg_rf_we_i = 1'b0;
    model_exec(rfop(3'd2, 3'd0, 6'd3));
    cmp_rf("R12 busy write dropped", 6'd20);
    cmp_state("R12 busy write");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule